// File: doc/BRIEF.md
# Floating-Point to 32-Bit Integer Converter

This block turns one IEEE-754 binary32 or binary64 operand into a 32-bit integer, signed or unsigned as a control input selects. Each accepted operand gives one registered result one clock later, together with two exception flags: Invalid Operation and Inexact. No other exception is ever raised.

The rounding is normally taken from a 2-bit mode input that mirrors a global control setting. A per-operation truncate bit forces rounding toward zero regardless of that mode. Results that fall outside the integer range saturate to fixed constants. Infinities saturate the same way. Every NaN gives zero.

Inside, the datapath unpacks the operand into sign, unbiased exponent and a 52-bit fraction. It then shifts the significand so that integer and fraction bits separate, adds the rounding increment, and passes the magnitude through a saturation stage. The output register holds the last result between operations.

Top module: `float_to_int_cvt`

## Requirements
- R1: When `rtz_i` is 1, the conversion rounds toward zero whatever `rmode_i` holds.
- R2: With `rtz_i` at 0, `rmode_i` selects the rounding: 2'b00 nearest with ties to even, 2'b01 toward +infinity, 2'b10 toward -infinity, 2'b11 toward zero.
- R3: In signed mode (`signed_i`=1), +infinity or a rounded value above 2^31-1 gives 32'h7FFFFFFF with Invalid set.
- R4: In signed mode, -infinity or a rounded value below -2^31 gives 32'h80000000 with Invalid set. The value -2^31 itself converts exactly.
- R5: In unsigned mode (`signed_i`=0), +infinity or a rounded value above 2^32-1 gives 32'hFFFFFFFF with Invalid set.
- R6: In unsigned mode, -infinity or a rounded value below 0 gives 32'h00000000 with Invalid set. A negative operand that rounds to zero gives 0 without Invalid.
- R7: Any NaN, quiet or signalling, of either sign and either width, gives 32'h00000000 with Invalid set.
- R8: Inexact is set exactly when fraction bits are discarded and Invalid is clear. Invalid and Inexact are never both set.
- R9: A denormal operand gives 0 under nearest-even and toward-zero rounding. It gives +1 or -1 (32'hFFFFFFFF) when directed rounding moves it away from zero. Inexact is set in every such case unless Invalid applies.
- R10: `valid_o` is high exactly one cycle after `valid_i` was sampled high. After reset `valid_o`, `result_o` and both flags are 0. Back-to-back operations are accepted every cycle.
- R11: When `dbl_i` is 0 the operand is `op_i[31:0]` as binary32, and `op_i[63:32]` has no effect. When `dbl_i` is 1, all 64 bits form a binary64 value.
- R12: A zero of either sign converts to 0 with neither flag set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operand and controls are valid this cycle |
| dbl_i | input | 1 | 1: binary64 operand, 0: binary32 in low half |
| signed_i | input | 1 | 1: signed result, 0: unsigned result |
| rtz_i | input | 1 | Force round toward zero |
| rmode_i | input | 2 | Rounding mode (encoding in R2) |
| op_i | input | 64 | Floating-point operand |
| valid_o | output | 1 | Result valid |
| result_o | output | 32 | Integer result |
| invalid_o | output | 1 | Invalid Operation flag |
| inexact_o | output | 1 | Inexact flag |

## Verification
The only state is the output register, so a fault in unpacking, shifting or rounding shows at the ports on the very next cycle as a wrong integer or a wrong flag for that operand. The most telling faults are off by one at a boundary: a wrong shift count, a tie broken the wrong way, or a limit compared with > instead of >=. The directed vectors therefore sit on each saturation limit and just beside it, on half-way values, and on denormals under every rounding mode. A wrong handshake shows as a result arriving in the wrong cycle or being lost, and the scoreboard queue catches that at once.

// File: rtl/fti_pkg.sv
package fti_pkg;
  localparam int DBL_EXP_W  = 11;
  localparam int DBL_FRAC_W = 52;
  localparam int DBL_BIAS   = 1023;
  localparam int SGL_EXP_W  = 8;
  localparam int SGL_FRAC_W = 23;
  localparam int SGL_BIAS   = 127;
  localparam int EXP_W      = DBL_EXP_W + 2;

  typedef enum logic [1:0] {
    RM_NEAREST = 2'b00,
    RM_UP      = 2'b01,
    RM_DOWN    = 2'b10,
    RM_ZERO    = 2'b11
  } rmode_e;

  typedef struct packed {
    logic                  sign;
    logic                  nan;
    logic                  inf;
    logic                  zero;
    logic                  denorm;
    logic [EXP_W-1:0]      exp;   // unbiased, two's complement
    logic [DBL_FRAC_W-1:0] frac;  // left aligned
  } unpacked_t;
endpackage

// File: rtl/fti_unpack.sv
module fti_unpack
  import fti_pkg::*;
(
  input  logic                      dbl_i,
  input  logic [2*32-1:0]           op_i,
  output unpacked_t                 unp_o
);
  localparam int PAD_W = DBL_FRAC_W - SGL_FRAC_W;

  logic [DBL_EXP_W-1:0]  eraw;
  logic [DBL_FRAC_W-1:0] frac;
  logic                  emax;
  logic [EXP_W-1:0]      bias;

  always_comb begin
    if (dbl_i) begin
      unp_o.sign = op_i[DBL_EXP_W+DBL_FRAC_W];
      eraw       = op_i[DBL_FRAC_W +: DBL_EXP_W];
      frac       = op_i[DBL_FRAC_W-1:0];
      emax       = &op_i[DBL_FRAC_W +: DBL_EXP_W];
      bias       = EXP_W'(DBL_BIAS);
    end else begin
      unp_o.sign = op_i[SGL_EXP_W+SGL_FRAC_W];
      eraw       = DBL_EXP_W'(op_i[SGL_FRAC_W +: SGL_EXP_W]);
      frac       = {op_i[SGL_FRAC_W-1:0], {PAD_W{1'b0}}};
      emax       = &op_i[SGL_FRAC_W +: SGL_EXP_W];
      bias       = EXP_W'(SGL_BIAS);
    end
    unp_o.nan    = emax && (frac != '0);
    unp_o.inf    = emax && (frac == '0);
    unp_o.zero   = (eraw == '0) && (frac == '0);
    unp_o.denorm = (eraw == '0) && (frac != '0);
    unp_o.exp    = EXP_W'(eraw) - bias;
    unp_o.frac   = frac;
  end
endmodule

// File: rtl/fti_align_round.sv
module fti_align_round
  import fti_pkg::*;
#(
  parameter int OUT_W = 32
) (
  input  unpacked_t          unp_i,
  input  rmode_e             rm_i,
  output logic [OUT_W+1:0]   mag_o,    // rounded magnitude
  output logic               huge_o,   // magnitude far beyond any limit
  output logic               lost_o    // nonzero bits discarded
);
  localparam int SIG_W = DBL_FRAC_W + 1;
  localparam int EXT_W = SIG_W + OUT_W;
  localparam int SH_W  = $clog2(OUT_W + 1);

  logic [EXT_W-1:0] shifted;
  logic [OUT_W:0]   ipart;
  logic             rnd, stk, inc, neg_exp;

  assign neg_exp = unp_i.exp[EXP_W-1];

  always_comb begin
    shifted = '0;
    ipart   = '0;
    rnd     = 1'b0;
    stk     = 1'b0;
    huge_o  = 1'b0;
    if (unp_i.nan || unp_i.inf) begin
      huge_o = 1'b1;
    end else if (unp_i.zero) begin
      stk = 1'b0;
    end else if (unp_i.denorm) begin
      stk = 1'b1;
    end else if (!neg_exp && (unp_i.exp > EXP_W'(OUT_W))) begin
      huge_o = 1'b1;
    end else if (!neg_exp) begin
      shifted = {{OUT_W{1'b0}}, 1'b1, unp_i.frac} << unp_i.exp[SH_W-1:0];
      ipart   = shifted[EXT_W-1:DBL_FRAC_W];
      rnd     = shifted[DBL_FRAC_W-1];
      stk     = |shifted[DBL_FRAC_W-2:0];
    end else if (unp_i.exp == '1) begin
      rnd = 1'b1;                 // hidden bit is the half bit
      stk = |unp_i.frac;
    end else begin
      stk = 1'b1;
    end
  end

  always_comb begin
    unique case (rm_i)
      RM_NEAREST: inc = rnd && (stk || ipart[0]);
      RM_UP:      inc = (rnd || stk) && !unp_i.sign;
      RM_DOWN:    inc = (rnd || stk) && unp_i.sign;
      default:    inc = 1'b0;
    endcase
  end

  assign mag_o  = {1'b0, ipart} + (OUT_W+2)'(inc);
  assign lost_o = rnd || stk;
endmodule

// File: rtl/fti_saturate.sv
module fti_saturate #(
  parameter int OUT_W = 32
) (
  input  logic               signed_i,
  input  logic               sign_i,
  input  logic               nan_i,
  input  logic               huge_i,
  input  logic               lost_i,
  input  logic [OUT_W+1:0]   mag_i,
  output logic [OUT_W-1:0]   res_o,
  output logic               invalid_o,
  output logic               inexact_o
);
  localparam int MAG_W = OUT_W + 2;
  localparam logic [MAG_W-1:0] LIM_POS_S = MAG_W'((64'd1 << (OUT_W-1)) - 64'd1);
  localparam logic [MAG_W-1:0] LIM_NEG_S = MAG_W'(64'd1 << (OUT_W-1));
  localparam logic [MAG_W-1:0] LIM_U     = MAG_W'((64'd1 << OUT_W) - 64'd1);
  localparam logic [OUT_W-1:0] S_MAX     = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] S_MIN     = {1'b1, {(OUT_W-1){1'b0}}};

  always_comb begin
    if (nan_i) begin
      invalid_o = 1'b1;
      res_o     = '0;
    end else if (signed_i && sign_i) begin
      invalid_o = huge_i || (mag_i > LIM_NEG_S);
      res_o     = invalid_o ? S_MIN : -mag_i[OUT_W-1:0];
    end else if (signed_i) begin
      invalid_o = huge_i || (mag_i > LIM_POS_S);
      res_o     = invalid_o ? S_MAX : mag_i[OUT_W-1:0];
    end else if (sign_i) begin
      invalid_o = huge_i || (mag_i != '0);
      res_o     = '0;
    end else begin
      invalid_o = huge_i || (mag_i > LIM_U);
      res_o     = invalid_o ? '1 : mag_i[OUT_W-1:0];
    end
    inexact_o = lost_i && !invalid_o;
  end
endmodule

// File: rtl/float_to_int_cvt.sv
module float_to_int_cvt
  import fti_pkg::*;
#(
  parameter int OUT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             dbl_i,
  input  logic             signed_i,
  input  logic             rtz_i,
  input  logic [1:0]       rmode_i,
  input  logic [63:0]      op_i,
  output logic             valid_o,
  output logic [OUT_W-1:0] result_o,
  output logic             invalid_o,
  output logic             inexact_o
);
  unpacked_t          unp;
  rmode_e             rm_eff;
  logic [OUT_W+1:0]   mag;
  logic               huge, lost;
  logic [OUT_W-1:0]   res_d;
  logic               inv_d, inx_d;

  assign rm_eff = rtz_i ? RM_ZERO : rmode_e'(rmode_i);

  fti_unpack u_unpack (
    .dbl_i (dbl_i),
    .op_i  (op_i),
    .unp_o (unp)
  );

  fti_align_round #(.OUT_W(OUT_W)) u_align (
    .unp_i  (unp),
    .rm_i   (rm_eff),
    .mag_o  (mag),
    .huge_o (huge),
    .lost_o (lost)
  );

  fti_saturate #(.OUT_W(OUT_W)) u_sat (
    .signed_i  (signed_i),
    .sign_i    (unp.sign),
    .nan_i     (unp.nan),
    .huge_i    (huge),
    .lost_i    (lost),
    .mag_i     (mag),
    .res_o     (res_d),
    .invalid_o (inv_d),
    .inexact_o (inx_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      result_o  <= '0;
      invalid_o <= 1'b0;
      inexact_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o  <= res_d;
        invalid_o <= inv_d;
        inexact_o <= inx_d;
      end
    end
  end

  localparam logic [OUT_W-1:0] S_MAX = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] S_MIN = {1'b1, {(OUT_W-1){1'b0}}};

  AST_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);  // R10
  AST_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);  // R10
  AST_FLAG_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !(invalid_o && inexact_o));  // R8
  AST_NAN_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && $past(unp.nan) |-> invalid_o && (result_o == '0));  // R7
  AST_SIGNED_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && invalid_o && $past(signed_i) && !$past(unp.nan)
      |-> (result_o == S_MAX) || (result_o == S_MIN));  // R3
  AST_UNS_NEG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !$past(signed_i) && $past(unp.sign) |-> (result_o == '0));  // R6
  AST_ZERO_EXACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && $past(unp.zero) |-> (result_o == '0) && !invalid_o && !inexact_o);  // R12
endmodule

// File: tb/float_to_int_cvt_bench.sv
`timescale 1ns/1ps
module float_to_int_cvt_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0, dbl_i = 1'b0, signed_i = 1'b0, rtz_i = 1'b0;
  logic [1:0]  rmode_i = 2'b00;
  logic [63:0] op_i = '0;
  logic        valid_o, invalid_o, inexact_o;
  logic [31:0] result_o;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [33:0] q_exp[$];
  string       q_tag[$];

  always #2 clk = ~clk;

  float_to_int_cvt u_float_to_int_cvt (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .dbl_i(dbl_i),
    .signed_i(signed_i), .rtz_i(rtz_i), .rmode_i(rmode_i), .op_i(op_i),
    .valid_o(valid_o), .result_o(result_o), .invalid_o(invalid_o),
    .inexact_o(inexact_o)
  );

  localparam logic [1:0] NE = 2'b00, UP = 2'b01, DN = 2'b10, TZ = 2'b11;
  localparam logic [31:0] JUNK = 32'hDEADBEEF;

  task automatic chk(input string tag, input logic [33:0] act, input logic [33:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: act res=%h inv=%b inx=%b exp res=%h inv=%b inx=%b",
               tag, act[33:2], act[1], act[0], exp[33:2], exp[1], exp[0]);
    end
  endtask

  // driver: one operation per call, back to back
  task automatic send(input string tag, input logic d, input logic s, input logic z,
                      input logic [1:0] rm, input logic [63:0] op,
                      input logic [31:0] r, input logic inv, input logic inx);
    @(negedge clk);
    valid_i = 1'b1; dbl_i = d; signed_i = s; rtz_i = z; rmode_i = rm; op_i = op;
    q_exp.push_back({r, inv, inx});
    q_tag.push_back(tag);
  endtask

  task automatic sgl(input string tag, input logic s, input logic z, input logic [1:0] rm,
                     input logic [31:0] f, input logic [31:0] r, input logic inv, input logic inx);
    send(tag, 1'b0, s, z, rm, {JUNK, f}, r, inv, inx);
  endtask

  task automatic dbl(input string tag, input logic s, input logic z, input logic [1:0] rm,
                     input logic [63:0] f, input logic [31:0] r, input logic inv, input logic inx);
    send(tag, 1'b1, s, z, rm, f, r, inv, inx);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_ni && valid_o) begin
        if (q_exp.size() == 0) begin
          chk("R10 unexpected valid_o", {result_o, invalid_o, inexact_o}, 34'h0);
        end else begin
          logic [33:0] e;
          string t;
          e = q_exp.pop_front();
          t = q_tag.pop_front();
          chk(t, {result_o, invalid_o, inexact_o}, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: act running exp finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset state", {result_o, invalid_o, inexact_o, 1'b0}, 34'h0);
    chk("R10 reset valid_o", {33'h0, valid_o}, 34'h0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    // basic rounding, binary32
    sgl("R2 1.0 ne",          1, 0, NE, 32'h3F800000, 32'd1,        0, 0);
    sgl("R2 2.5 ne tie even", 1, 0, NE, 32'h40200000, 32'd2,        0, 1);
    sgl("R2 2.5 up",          1, 0, UP, 32'h40200000, 32'd3,        0, 1);
    sgl("R2 -2.5 down",       1, 0, DN, 32'hC0200000, 32'hFFFFFFFD, 0, 1);
    sgl("R2 -2.5 up",         1, 0, UP, 32'hC0200000, 32'hFFFFFFFE, 0, 1);
    sgl("R2 0.75 ne",         1, 0, NE, 32'h3F400000, 32'd1,        0, 1);
    sgl("R2 2.5 mode tz",     1, 0, TZ, 32'h40200000, 32'd2,        0, 1);
    // override
    sgl("R1 2.5 rtz over up", 1, 1, UP, 32'h40200000, 32'd2,        0, 1);
    sgl("R1 -2.5 rtz over dn",1, 1, DN, 32'hC0200000, 32'hFFFFFFFE, 0, 1);
    // binary64
    dbl("R2 d 3.5 ne",   1, 0, NE, 64'h400C000000000000, 32'd4,        0, 1);
    dbl("R2 d -1.5 ne",  1, 0, NE, 64'hBFF8000000000000, 32'hFFFFFFFE, 0, 1);
    dbl("R1 d -1.5 rtz", 1, 1, NE, 64'hBFF8000000000000, 32'hFFFFFFFF, 0, 1);
    dbl("R2 d 0.5 ne",   1, 0, NE, 64'h3FE0000000000000, 32'd0,        0, 1);
    dbl("R2 d 0.5 up",   1, 0, UP, 64'h3FE0000000000000, 32'd1,        0, 1);
    // signed limits
    dbl("R4 d -2^31 exact",   1, 0, NE, 64'hC1E0000000000000, 32'h80000000, 0, 0);
    dbl("R3 d 2^31",          1, 0, NE, 64'h41E0000000000000, 32'h7FFFFFFF, 1, 0);
    dbl("R3 d 2^31-1 exact",  1, 0, NE, 64'h41DFFFFFFFC00000, 32'h7FFFFFFF, 0, 0);
    dbl("R3 d 2^31-.5 ne",    1, 0, NE, 64'h41DFFFFFFFE00000, 32'h7FFFFFFF, 1, 0);
    dbl("R1 d 2^31-.5 rtz",   1, 1, NE, 64'h41DFFFFFFFE00000, 32'h7FFFFFFF, 0, 1);
    sgl("R4 s -2^31 exact",   1, 0, NE, 32'hCF000000, 32'h80000000, 0, 0);
    sgl("R3 s huge",          1, 0, NE, 32'h7149F2CA, 32'h7FFFFFFF, 1, 0);
    sgl("R4 s -inf",          1, 0, NE, 32'hFF800000, 32'h80000000, 1, 0);
    sgl("R3 s +inf",          1, 0, NE, 32'h7F800000, 32'h7FFFFFFF, 1, 0);
    dbl("R4 d -2^32",         1, 0, NE, 64'hC1F0000000000000, 32'h80000000, 1, 0);
    // unsigned limits
    dbl("R5 d 2^32-1 exact",  0, 0, NE, 64'h41EFFFFFFFE00000, 32'hFFFFFFFF, 0, 0);
    dbl("R5 d 2^32",          0, 0, NE, 64'h41F0000000000000, 32'hFFFFFFFF, 1, 0);
    sgl("R5 s max below 2^32",0, 0, NE, 32'h4F7FFFFF, 32'hFFFFFF00, 0, 0);
    sgl("R5 s 2^31 unsigned", 0, 0, NE, 32'h4F000000, 32'h80000000, 0, 0);
    sgl("R5 s +inf",          0, 0, NE, 32'h7F800000, 32'hFFFFFFFF, 1, 0);
    sgl("R6 s -inf",          0, 0, NE, 32'hFF800000, 32'h00000000, 1, 0);
    sgl("R6 s -1.0",          0, 0, NE, 32'hBF800000, 32'h00000000, 1, 0);
    sgl("R6 s -2^31",         0, 0, NE, 32'hCF000000, 32'h00000000, 1, 0);
    sgl("R6 s -0.75 ne",      0, 0, NE, 32'hBF400000, 32'h00000000, 1, 0);
    sgl("R6 s -0.75 up",      0, 0, UP, 32'hBF400000, 32'h00000000, 0, 1);
    sgl("R6 s -0.75 rtz",     0, 1, NE, 32'hBF400000, 32'h00000000, 0, 1);
    // NaN
    sgl("R7 s qnan signed",   1, 0, NE, 32'h7FC00000, 32'h0, 1, 0);
    sgl("R7 s -nan unsigned", 0, 0, UP, 32'hFFC00000, 32'h0, 1, 0);
    sgl("R7 s snan",          1, 0, NE, 32'h7F800001, 32'h0, 1, 0);
    dbl("R7 d qnan",          1, 0, DN, 64'h7FF8000000000000, 32'h0, 1, 0);
    dbl("R7 d snan unsigned", 0, 0, NE, 64'h7FF0000000000001, 32'h0, 1, 0);
    // denormals
    sgl("R9 s denorm ne",     1, 0, NE, 32'h00000001, 32'd0,        0, 1);
    sgl("R9 s denorm up",     1, 0, UP, 32'h00000001, 32'd1,        0, 1);
    sgl("R9 s denorm dn",     1, 0, DN, 32'h00000001, 32'd0,        0, 1);
    sgl("R9 s -denorm dn",    1, 0, DN, 32'h80000001, 32'hFFFFFFFF, 0, 1);
    sgl("R9 s -denorm tz",    1, 0, TZ, 32'h80000001, 32'd0,        0, 1);
    dbl("R9 d denorm up",     1, 0, UP, 64'h0000000000000001, 32'd1,        0, 1);
    dbl("R9 d -denorm rtz",   1, 1, DN, 64'h8000000000000001, 32'd0,        0, 1);
    // zeros
    sgl("R12 s +0",           1, 0, UP, 32'h00000000, 32'd0, 0, 0);
    dbl("R12 d -0 unsigned",  0, 0, DN, 64'h8000000000000000, 32'd0, 0, 0);
    // width select: upper half ignored for binary32, used for binary64
    send("R11 s ignores upper", 1'b0, 1, 0, NE, 64'h7FF8000000000000 | 64'h3F800000, 32'd1, 0, 0);
    send("R11 d uses upper",    1'b1, 1, 0, NE, 64'h4004000000000000, 32'd2, 0, 1);
    // flag exclusivity on exact value
    sgl("R8 exact no inexact",1, 0, UP, 32'h41200000, 32'd10, 0, 0);

    @(negedge clk);
    valid_i = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10 idle valid_o low", {33'h0, valid_o}, 34'h0);
    chk("R10 queue drained", {2'b0, 32'(q_exp.size())}, 34'h0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule